// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block keeps a record of every memory request that has been sent downstream and has not yet had its response. It holds two fully associative tables of cache-line addresses. One table is for the read class and one is for the write class. Before the issue stage commits a new request, it presents that request on the check port. The block then answers in the same cycle with one of three results: ready, aliased (the line conflicts with work in flight or is locked) or full (no room).

When the issue stage sends a request that was ready, it pulses the allocate port, and the line goes into the table for its class. When a response returns with a line address and a class bit, the block frees the matching entry. A response that finds no entry raises a sticky error. Each entry carries an age counter. While anything is outstanding, a periodic scan raises a sticky deadlock flag once an entry has waited for the threshold number of cycles. Four stall counters record the reason each valid check was refused because of a conflict with a table.

Top module: `olt_tracker`

## Requirements
- R1: Request kinds are 4-bit codes: 0 load and 1 instruction fetch belong to the read class. Kinds 2 to 12 belong to the write class: store, atomic, atomic-with-return, atomic-no-return, read-modify-write read/write, load-linked, store-conditional, locked read-modify-write read (10) and write (11), and flush. An allocation enters the table of its class.
- R2: The check result is 2-bit: 0 ready, 1 aliased, 2 full. A check whose line matches a valid entry in either table returns aliased, whatever the class of the request.
- R3: A check returns full when the outstanding count is at or above MAX_OUT or when the downstream-full input is high. Full takes priority over every aliased cause. MAX_OUT must not exceed ENTRIES.
- R4: When the blocked input is high and full does not apply, the check returns aliased for every kind except 11. A kind-11 request on a blocked line is judged on the tables alone.
- R5: A valid check that a table conflict refuses increments exactly one counter. A write-class request increments store-waits-on-load if the read table holds the line, and otherwise store-waits-on-store. A read-class request increments load-waits-on-store if the write table holds the line, and otherwise load-waits-on-load. A refusal for full or for the blocked input changes no counter.
- R6: While the count is non-zero, a scan fires every THRESH cycles. The deadlock output goes high, and stays high until reset, at a scan where some entry's age has reached THRESH.
- R7: The outstanding count always equals the total occupancy of both tables. An allocation and a release in the same cycle leave the count unchanged.
- R8: A response frees the entry with its line address in the table chosen by its class bit (1 = write class). After that, a check of the line returns ready.
- R9: A response whose line is not in the selected table leaves both tables unchanged and sets a sticky protocol-error output.
- R10: Reset empties both tables and clears the count, the stall counters, the deadlock flag and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | A request is being checked this cycle (gates the stall counters) |
| chk_kind | input | 4 | Kind code of the checked request |
| chk_line | input | LINE_W | Line address of the checked request |
| chk_blocked | input | 1 | The controller holds the checked line blocked |
| dq_full | input | 1 | Downstream queue has no free slot |
| chk_status | output | 2 | 0 ready, 1 aliased, 2 full |
| alloc_valid | input | 1 | Record an issued request |
| alloc_kind | input | 4 | Kind code of the issued request |
| alloc_line | input | LINE_W | Line address of the issued request |
| rsp_valid | input | 1 | A response is returning |
| rsp_write | input | 1 | Class of the response: 1 write, 0 read |
| rsp_line | input | LINE_W | Line address of the response |
| out_count | output | CNT_W | Entries in flight |
| deadlock | output | 1 | Sticky possible-deadlock flag |
| proto_err | output | 1 | Sticky unmatched-response flag |
| st_wait_ld | output | STALL_W | Store-waits-on-load count |
| st_wait_st | output | STALL_W | Store-waits-on-store count |
| ld_wait_st | output | STALL_W | Load-waits-on-store count |
| ld_wait_ld | output | STALL_W | Load-waits-on-load count |

## Verification
The assertions assume that allocations come only after a ready check. This means no line is allocated twice, and no allocation arrives when the count is already at MAX_OUT. The one-hot match check and the count-versus-occupancy check depend on that assumption. The random stimulus keeps within it in two ways. It raises allocate only in cycles where its own model predicts ready for that same line. It sends responses only for lines the model holds in the matching class. Unmatched responses appear only in a directed case.

// File: rtl/olt_pkg.sv
package olt_pkg;
    typedef enum logic [1:0] {
        CHK_READY = 2'd0,
        CHK_ALIAS = 2'd1,
        CHK_FULL  = 2'd2
    } chk_status_e;

    localparam logic [3:0] KIND_LOCK_WR = 4'd11;

    function automatic logic is_write_class(input logic [3:0] kind);
        return kind >= 4'd2;
    endfunction
endpackage

// File: rtl/olt_table.sv
module olt_table #(
    parameter int ENTRIES = 8,
    parameter int LINE_W  = 32,
    parameter int THRESH  = 64,
    parameter int TCNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] lk_line,
    input  logic              alloc_en,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic              free_en,
    input  logic [LINE_W-1:0] free_line,
    output logic              lk_hit,
    output logic              free_hit,
    output logic [TCNT_W-1:0] occ,
    output logic              aged
);
    localparam int AGE_W = $clog2(THRESH + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(THRESH);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][LINE_W-1:0] line;
        logic [ENTRIES-1:0][AGE_W-1:0]  age;
    } tbl_t;

    tbl_t s_d, s_q;
    logic [ENTRIES-1:0] lk_match, fr_match;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            lk_match[i] = s_q.vld[i] && (s_q.line[i] == lk_line);
            fr_match[i] = s_q.vld[i] && (s_q.line[i] == free_line);
        end
    end

    assign lk_hit   = |lk_match;
    assign free_hit = |fr_match;

    always_comb begin
        logic placed;
        s_d    = s_q;
        placed = 1'b0;
        occ    = '0;
        aged   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (s_q.vld[i]) begin
                occ = occ + 1'b1;
                if (s_q.age[i] >= AGE_MAX) aged = 1'b1;
                else s_d.age[i] = s_q.age[i] + 1'b1;
            end
            if (free_en && fr_match[i]) s_d.vld[i] = 1'b0;
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (alloc_en && !placed && !s_q.vld[i]) begin
                s_d.vld[i]  = 1'b1;
                s_d.line[i] = alloc_line;
                s_d.age[i]  = '0;
                placed      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: a line is held at most once, so a response frees at most one slot
    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fr_match));
    // R7: allocation only into a table with room
    assert_table_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (occ < TCNT_W'(ENTRIES)));
endmodule

// File: rtl/olt_tracker.sv
module olt_tracker
    import olt_pkg::*;
#(
    parameter int LINE_W  = 32,
    parameter int ENTRIES = 8,
    parameter int MAX_OUT = 8,
    parameter int THRESH  = 64,
    parameter int STALL_W = 16,
    parameter int CNT_W   = $clog2(2 * ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_valid,
    input  logic [3:0]         chk_kind,
    input  logic [LINE_W-1:0]  chk_line,
    input  logic               chk_blocked,
    input  logic               dq_full,
    output logic [1:0]         chk_status,
    input  logic               alloc_valid,
    input  logic [3:0]         alloc_kind,
    input  logic [LINE_W-1:0]  alloc_line,
    input  logic               rsp_valid,
    input  logic               rsp_write,
    input  logic [LINE_W-1:0]  rsp_line,
    output logic [CNT_W-1:0]   out_count,
    output logic               deadlock,
    output logic               proto_err,
    output logic [STALL_W-1:0] st_wait_ld,
    output logic [STALL_W-1:0] st_wait_st,
    output logic [STALL_W-1:0] ld_wait_st,
    output logic [STALL_W-1:0] ld_wait_ld
);
    localparam int TCNT_W = $clog2(ENTRIES + 1);
    localparam int SCAN_W = $clog2(THRESH + 1);
    localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(THRESH - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX   = CNT_W'(MAX_OUT);

    typedef struct packed {
        logic [CNT_W-1:0]        cnt;
        logic [SCAN_W-1:0]       scan;
        logic                    dl;
        logic                    perr;
        logic [3:0][STALL_W-1:0] stall;
    } st_t;

    st_t r_d, r_q;
    chk_status_e status;
    logic [1:0] hit, fhit, aged;
    logic [1:0][TCNT_W-1:0] occ;
    logic chk_wr, alloc_wr, rsp_ok;

    assign chk_wr   = is_write_class(chk_kind);
    assign alloc_wr = is_write_class(alloc_kind);

    // index 0: read table, index 1: write table
    for (genvar g = 0; g < 2; g++) begin : g_tbl
        olt_table #(
            .ENTRIES(ENTRIES), .LINE_W(LINE_W), .THRESH(THRESH), .TCNT_W(TCNT_W)
        ) u_tbl (
            .clk       (clk),
            .rst_n     (rst_n),
            .lk_line   (chk_line),
            .alloc_en  (alloc_valid && (alloc_wr == 1'(g))),
            .alloc_line(alloc_line),
            .free_en   (rsp_valid && (rsp_write == 1'(g))),
            .free_line (rsp_line),
            .lk_hit    (hit[g]),
            .free_hit  (fhit[g]),
            .occ       (occ[g]),
            .aged      (aged[g])
        );
    end

    assign rsp_ok = rsp_write ? fhit[1] : fhit[0];

    always_comb begin
        r_d = r_q;
        if ((r_q.cnt >= CNT_MAX) || dq_full)              status = CHK_FULL;
        else if (chk_blocked && chk_kind != KIND_LOCK_WR) status = CHK_ALIAS;
        else if (|hit)                                    status = CHK_ALIAS;
        else                                              status = CHK_READY;

        if (chk_valid && status == CHK_ALIAS && !(chk_blocked && chk_kind != KIND_LOCK_WR)) begin
            if (chk_wr) begin
                if (hit[0]) r_d.stall[0] = r_q.stall[0] + 1'b1;
                else        r_d.stall[1] = r_q.stall[1] + 1'b1;
            end else begin
                if (hit[1]) r_d.stall[2] = r_q.stall[2] + 1'b1;
                else        r_d.stall[3] = r_q.stall[3] + 1'b1;
            end
        end

        r_d.cnt = r_q.cnt + CNT_W'(alloc_valid) - CNT_W'(rsp_valid && rsp_ok);
        if (rsp_valid && !rsp_ok) r_d.perr = 1'b1;

        if (r_q.cnt == '0) begin
            r_d.scan = '0;
        end else if (r_q.scan >= SCAN_LAST) begin
            r_d.scan = '0;
            if (|aged) r_d.dl = 1'b1;
        end else begin
            r_d.scan = r_q.scan + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign chk_status = status;
    assign out_count  = r_q.cnt;
    assign deadlock   = r_q.dl;
    assign proto_err  = r_q.perr;
    assign st_wait_ld = r_q.stall[0];
    assign st_wait_st = r_q.stall[1];
    assign ld_wait_st = r_q.stall[2];
    assign ld_wait_ld = r_q.stall[3];

    assert_count_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt == (CNT_W'(occ[0]) + CNT_W'(occ[1])));
    assert_downstream_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_full |-> chk_status == 2'd2);
    assert_alloc_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |-> r_q.cnt < CNT_MAX);
    assert_deadlock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |=> deadlock);
    assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

// File: tb/tb_olt_tracker.sv
module tb_olt_tracker;
    localparam int LW = 8, NE = 4, MO = 4, TH = 20, SW = 16;
    localparam int CW = $clog2(2 * NE + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic chk_valid = 0, chk_blocked = 0, dq_full = 0;
    logic [3:0] chk_kind = 0, alloc_kind = 0;
    logic [LW-1:0] chk_line = 0, alloc_line = 0, rsp_line = 0;
    logic alloc_valid = 0, rsp_valid = 0, rsp_write = 0;
    logic [1:0] chk_status;
    logic [CW-1:0] out_count;
    logic deadlock, proto_err;
    logic [SW-1:0] st_wait_ld, st_wait_st, ld_wait_st, ld_wait_ld;

    always #5 clk = ~clk;

    olt_tracker #(.LINE_W(LW), .ENTRIES(NE), .MAX_OUT(MO), .THRESH(TH), .STALL_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_kind(chk_kind),
        .chk_line(chk_line), .chk_blocked(chk_blocked), .dq_full(dq_full),
        .chk_status(chk_status), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
        .alloc_line(alloc_line), .rsp_valid(rsp_valid), .rsp_write(rsp_write),
        .rsp_line(rsp_line), .out_count(out_count), .deadlock(deadlock),
        .proto_err(proto_err), .st_wait_ld(st_wait_ld), .st_wait_st(st_wait_st),
        .ld_wait_st(ld_wait_st), .ld_wait_ld(ld_wait_ld)
    );

    int n_chk = 0, n_bad = 0;
    bit rdm[256];
    bit wrm[256];
    int m_cnt;
    int m_stall[4];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    function automatic bit wr_class(input logic [3:0] k);
        return k >= 4'd2;
    endfunction

    function automatic int exp_status(input logic [3:0] k, input int l, input bit blk, input bit dqf);
        if (m_cnt >= MO || dqf) return 2;
        if (blk && k != 4'd11) return 1;
        if (rdm[l] || wrm[l]) return 1;
        return 0;
    endfunction

    task automatic idle();
        chk_valid = 0; chk_blocked = 0; dq_full = 0; chk_kind = 0; chk_line = 0;
        alloc_valid = 0; alloc_kind = 0; alloc_line = 0;
        rsp_valid = 0; rsp_write = 0; rsp_line = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        foreach (rdm[i]) begin rdm[i] = 0; wrm[i] = 0; end
        m_cnt = 0;
        foreach (m_stall[i]) m_stall[i] = 0;
    endtask

    // one directed cycle: inputs already set at negedge, wait through the edge
    task automatic edge_step();
        @(posedge clk); #1;
        @(negedge clk);
        idle();
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R10: reset state
        check("R10 count", int'(out_count), 0);
        check("R10 deadlock", int'(deadlock), 0);
        check("R10 proto_err", int'(proto_err), 0);
        check("R10 stalls", int'(st_wait_ld + st_wait_st + ld_wait_st + ld_wait_ld), 0);
        check("R10 status", int'(chk_status), 0);

        // random phase against the bench model (R2 R3 R4 R5 R7 R8)
        for (int cyc = 0; cyc < 3000; cyc++) begin
            int es, l, rl;
            bit rw, hr, hw;
            logic [3:0] k;
            k  = 4'($urandom % 13);
            l  = int'($urandom % 8);
            chk_valid   = ($urandom % 4) != 0;
            chk_kind    = k;
            chk_line    = LW'(l);
            chk_blocked = ($urandom % 8) == 0;
            dq_full     = ($urandom % 8) == 0;
            #2;
            es = exp_status(k, l, chk_blocked, dq_full);
            check("R2/R3/R4 status", int'(chk_status), es);
            hr = rdm[l]; hw = wrm[l];
            if (es == 0 && ($urandom % 2) == 1) begin
                alloc_valid = 1; alloc_kind = k; alloc_line = LW'(l);
            end
            rl = int'($urandom % 8); rw = $urandom % 2;
            if ((rw ? wrm[rl] : rdm[rl]) && ($urandom % 2) == 1) begin
                rsp_valid = 1; rsp_write = rw; rsp_line = LW'(rl);
            end
            @(posedge clk);
            if (chk_valid && es == 1 && !(chk_blocked && k != 4'd11)) begin
                if (wr_class(k)) m_stall[hr ? 0 : 1]++;
                else             m_stall[hw ? 2 : 3]++;
            end
            if (rsp_valid) begin
                if (rsp_write) wrm[rl] = 0; else rdm[rl] = 0;
                m_cnt--;
            end
            if (alloc_valid) begin
                if (wr_class(k)) wrm[l] = 1; else rdm[l] = 1;
                m_cnt++;
            end
            #1;
            check("R7 count", int'(out_count), m_cnt);
            check("R5 st_wait_ld", int'(st_wait_ld), m_stall[0]);
            check("R5 st_wait_st", int'(st_wait_st), m_stall[1]);
            check("R5 ld_wait_st", int'(ld_wait_st), m_stall[2]);
            check("R5 ld_wait_ld", int'(ld_wait_ld), m_stall[3]);
            @(negedge clk);
            idle();
        end

        // R1 and R9: store lands in the write table
        do_reset();
        alloc_valid = 1; alloc_kind = 4'd2; alloc_line = 8'd5;
        edge_step();
        rsp_valid = 1; rsp_write = 0; rsp_line = 8'd5;
        edge_step();
        check("R9 proto_err on wrong class", int'(proto_err), 1);
        check("R9 count unchanged", int'(out_count), 1);
        rsp_valid = 1; rsp_write = 1; rsp_line = 8'd5;
        edge_step();
        check("R8 freed by write response", int'(out_count), 0);
        check("R9 error sticky", int'(proto_err), 1);
        chk_kind = 4'd0; chk_line = 8'd5; #1;
        check("R8 ready after free", int'(chk_status), 0);
        // load-linked is write class: a load on it counts load-waits-on-store
        alloc_valid = 1; alloc_kind = 4'd8; alloc_line = 8'd6;
        edge_step();
        chk_valid = 1; chk_kind = 4'd0; chk_line = 8'd6; #1;
        check("R2 alias across class", int'(chk_status), 1);
        edge_step();
        check("R1/R5 ld_wait_st", int'(ld_wait_st), 1);
        check("R5 ld_wait_ld", int'(ld_wait_ld), 0);

        // R4: blocked line
        do_reset();
        chk_valid = 1; chk_blocked = 1; chk_kind = 4'd11; chk_line = 8'd9; #1;
        check("R4 locked write passes block", int'(chk_status), 0);
        chk_kind = 4'd0; #1;
        check("R4 load blocked", int'(chk_status), 1);
        edge_step();
        check("R4/R5 no stall on block", int'(ld_wait_ld + ld_wait_st), 0);

        // R3: full takes priority
        do_reset();
        for (int i = 0; i < 4; i++) begin
            alloc_valid = 1; alloc_kind = 4'(i % 2); alloc_line = 8'(20 + i);
            edge_step();
        end
        check("R7 count four", int'(out_count), 4);
        chk_valid = 1; chk_kind = 4'd0; chk_line = 8'd99; #1;
        check("R3 full at max", int'(chk_status), 2);
        chk_line = 8'd20; #1;
        check("R3 full over alias", int'(chk_status), 2);
        edge_step();
        check("R3/R5 no stall when full", int'(ld_wait_ld), 0);

        // R7: alloc and free in one cycle
        do_reset();
        alloc_valid = 1; alloc_kind = 4'd0; alloc_line = 8'd1;
        edge_step();
        alloc_valid = 1; alloc_kind = 4'd2; alloc_line = 8'd2;
        rsp_valid = 1; rsp_write = 0; rsp_line = 8'd1;
        edge_step();
        check("R7 same-cycle alloc/free", int'(out_count), 1);
        dq_full = 1; #1;
        check("R3 downstream full", int'(chk_status), 2);
        idle();
        rsp_valid = 1; rsp_write = 1; rsp_line = 8'd2;
        edge_step();
        check("R8 write entry freed", int'(out_count), 0);
        check("R9 no error on matches", int'(proto_err), 0);

        // R6: deadlock watchdog
        do_reset();
        alloc_valid = 1; alloc_kind = 4'd0; alloc_line = 8'd3;
        edge_step();
        repeat (TH / 2) @(posedge clk);
        #1;
        check("R6 no early deadlock", int'(deadlock), 0);
        repeat (2 * TH) @(posedge clk);
        #1;
        check("R6 deadlock raised", int'(deadlock), 1);
        @(negedge clk);
        rsp_valid = 1; rsp_write = 0; rsp_line = 8'd3;
        edge_step();
        repeat (3) @(posedge clk);
        #1;
        check("R6 deadlock sticky", int'(deadlock), 1);
        check("R8 count after response", int'(out_count), 0);

        finish_run();
    end
endmodule